// File: doc/BRIEF.md
# Compare-Match System Timer

This block is a memory-mapped timer for a system tick. A free-running up-counter advances on a slow timer-clock enable input, after a programmable prescaler, and wraps modulo 2^CNT_W. When the counter arrives at the value held in a 32-bit match register while counting is enabled, the block emits a one-cycle interrupt pulse. Software arms the next event by reading the counter, adding a delay and writing the sum to the match register.

A control register has two bits. One starts and stops the count. The other makes the counter fall back to zero on its next step after a match, which gives periodic operation with period match+1 steps. Any write to the clear register zeroes the counter. A 2-bit divider field makes the counter step once every 1, 2, 3 or 4 timer-clock enables. The register bus is a single-cycle select/write strobe with a combinational read path.

Register offsets (byte addresses) are: match 0x00, count 0x04 (read only), control 0x08, clear 0x0C (write only) and divider 0x34.

Top module: `cmp_timer`

## Requirements
- R1: After reset the count reads 0, control reads 0, divider reads 0, match reads 0xFFFF_FFFF and irq is 0.
- R2: With control bit 0 set and divider 0, the count rises by exactly one for every cycle in which tick_en is 1, and holds when tick_en is 0.
- R3: With control bit 0 clear, the count holds its value and irq stays 0, even when the count equals the match value.
- R4: A write of any data to offset 0x0C sets the count to 0 on that clock edge, overriding an increment due on the same edge.
- R5: Divider value d (bits 1:0 at offset 0x34) makes the counter step once per d+1 tick_en cycles, so N ticks after a clear give a count of floor(N/(d+1)).
- R6: irq is high for exactly one cycle, in the cycle after the count first equals the match value while counting is enabled. It does not repeat while the count stays at that value.
- R7: With control bits 1 and 0 both set, a step taken while the count equals the match value loads 0 instead of incrementing, giving one irq every match+1 steps.
- R8: The count wraps from 2^CNT_W-1 to 0.
- R9: A match value the count has already passed raises no irq until the count wraps around and reaches it.
- R10: Reads of unmapped offsets, and of the clear offset, return 0. Writes to unmapped offsets or to the count offset change no register.
- R11: The match register reads back all 32 bits written. Control and divider read back their 2 bits, and their upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timer clock enable; one prescaler input pulse per cycle high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe, else 0 |
| irq | output | 1 | One-cycle compare-match interrupt pulse |

## Verification
The assertions assume that reset is applied at start and that the bus strobes are held for whole cycles. They also assume a clear write is the only way the count can leave the sequence "hold, +1, or 0". The bench keeps tick_en low during every register access except the one deliberate clear-while-counting case, so that step counts are known exactly. It reduces CNT_W to 10 so that wrap and passed-match cases finish in about a thousand ticks.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFS_MATCH = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_COUNT = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] OFS_CLEAR = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] OFS_DIV   = ADDR_W'('h34);

  logic [31:0]      match_q;
  logic [CNT_W-1:0] count_q;
  logic             run_q, wrap_q;
  logic [DIV_W-1:0] div_q, pre_q;
  logic             hit, hit_q, step;
  logic             wr_match, wr_ctrl, wr_clr, wr_div;

  wire do_wr = bus_sel & bus_wr;
  assign wr_match = do_wr & (bus_addr == OFS_MATCH);
  assign wr_ctrl  = do_wr & (bus_addr == OFS_CTRL);
  assign wr_clr   = do_wr & (bus_addr == OFS_CLEAR);
  assign wr_div   = do_wr & (bus_addr == OFS_DIV);

  assign hit  = run_q & (32'(count_q) == match_q);
  assign step = run_q & tick_en & (pre_q == div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '1;
      run_q   <= 1'b0;
      wrap_q  <= 1'b0;
      div_q   <= '0;
    end else begin
      if (wr_match) match_q <= bus_wdata;
      if (wr_ctrl) begin
        run_q  <= bus_wdata[0];
        wrap_q <= bus_wdata[1];
      end
      if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_q <= '0;
    else if (!run_q || wr_clr) pre_q <= '0;
    else if (tick_en)          pre_q <= (pre_q == div_q) ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (wr_clr) count_q <= '0;
    else if (step)   count_q <= (wrap_q && hit) ? '0 : count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      hit_q <= hit;
      irq   <= hit & ~hit_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFS_MATCH: bus_rdata = match_q;
        OFS_COUNT: bus_rdata = 32'(count_q);
        OFS_CTRL:  bus_rdata = {30'd0, wrap_q, run_q};
        OFS_DIV:   bus_rdata = 32'(div_q);
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

module cmp_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             run,
  input logic             clr_wr,
  input logic [CNT_W-1:0] count,
  input logic [31:0]      match
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> (count == $past(count)) || (count == CNT_W'($past(count) + 1'b1)) || (count == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr_wr) |=> $stable(count));

  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !irq);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (count == '0));

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(run) && ($past(32'(count)) == $past(match))));
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .irq    (irq),
  .run    (run_q),
  .clr_wr (wr_clr),
  .count  (count_q),
  .match  (match_q)
);

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
  localparam int CW = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;

  always #5 clk = ~clk;

  cmp_timer #(.CNT_W(CW), .ADDR_W(8), .DIV_W(2)) i_cmp_timer (
    .clk, .rst_n, .tick_en, .bus_sel, .bus_wr, .bus_addr,
    .bus_wdata, .bus_rdata, .irq
  );

  always @(negedge clk) if (irq) irq_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic restart(input logic [31:0] ctrl, input logic [31:0] dv, input logic [31:0] m);
    wr(8'h08, 32'h0);
    wr(8'h34, dv);
    wr(8'h00, m);
    wr(8'h0C, 32'h0);
    wr(8'h08, ctrl);
  endtask

  task automatic t_reset_r1();
    logic [31:0] v;
    chk("R1 irq", 32'(irq), 0);
    rd(8'h04, v); chk("R1 count", v, 0);
    rd(8'h08, v); chk("R1 ctrl", v, 0);
    rd(8'h34, v); chk("R1 div", v, 0);
    rd(8'h00, v); chk("R1 match", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_count_r2();
    logic [31:0] v;
    restart(1, 0, 32'hFFFF_FFFF);
    ticks(7);
    repeat (3) @(negedge clk);
    rd(8'h04, v); chk("R2 count after 7 ticks", v, 7);
  endtask

  task automatic t_disabled_r3();
    logic [31:0] v;
    int base;
    restart(1, 0, 32'hFFFF_FFFF);
    ticks(4);
    wr(8'h08, 0);
    wr(8'h00, 4);
    base = irq_cnt;
    ticks(9);
    repeat (3) @(negedge clk);
    rd(8'h04, v); chk("R3 count holds", v, 4);
    chk("R3 no irq at equal count", irq_cnt - base, 0);
  endtask

  task automatic t_clear_r4();
    logic [31:0] v;
    restart(1, 0, 32'hFFFF_FFFF);
    ticks(5);
    @(negedge clk);
    tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    rd(8'h04, v); chk("R4 clear beats increment", v, 0);
  endtask

  task automatic t_div_r5();
    logic [31:0] v;
    for (int d = 0; d < 4; d++) begin
      restart(1, d, 32'hFFFF_FFFF);
      ticks(12);
      rd(8'h04, v); chk("R5 divided count", v, 12 / (d + 1));
    end
    restart(1, 2, 32'hFFFF_FFFF);
    ticks(8);
    rd(8'h04, v); chk("R5 div3 partial", v, 2);
  endtask

  task automatic t_irq_r6();
    int base;
    restart(1, 0, 5);
    base = irq_cnt;
    ticks(5);
    chk("R6 irq low at match cycle", 32'(irq), 0);
    @(negedge clk);
    chk("R6 irq high next cycle", 32'(irq), 1);
    @(negedge clk);
    chk("R6 irq one cycle", 32'(irq), 0);
    repeat (5) @(negedge clk);
    chk("R6 single pulse while parked", irq_cnt - base, 1);
  endtask

  task automatic t_periodic_r7();
    logic [31:0] v;
    int base;
    restart(3, 0, 3);
    base = irq_cnt;
    ticks(12);
    repeat (3) @(negedge clk);
    rd(8'h04, v); chk("R7 count back to zero", v, 0);
    chk("R7 periodic irq count", irq_cnt - base, 3);
  endtask

  task automatic t_wrap_r8();
    logic [31:0] v;
    restart(1, 0, 32'hFFFF_FFFF);
    ticks(1030);
    rd(8'h04, v); chk("R8 wrapped count", v, 6);
  endtask

  task automatic t_passed_r9();
    logic [31:0] v;
    int base;
    restart(1, 0, 32'hFFFF_FFFF);
    ticks(20);
    wr(8'h00, 10);
    base = irq_cnt;
    ticks(1013);
    repeat (3) @(negedge clk);
    rd(8'h04, v); chk("R9 count before wrap match", v, 9);
    chk("R9 no early irq", irq_cnt - base, 0);
    ticks(1);
    repeat (3) @(negedge clk);
    chk("R9 irq after wrap", irq_cnt - base, 1);
  endtask

  task automatic t_unmapped_r10();
    logic [31:0] v;
    restart(1, 1, 32'h0000_0123);
    ticks(6);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h04, 32'h55);
    rd(8'h10, v); chk("R10 unmapped read", v, 0);
    rd(8'h0C, v); chk("R10 clear reads zero", v, 0);
    rd(8'h04, v); chk("R10 count untouched", v, 3);
    rd(8'h00, v); chk("R10 match untouched", v, 32'h123);
    rd(8'h08, v); chk("R10 ctrl untouched", v, 1);
    rd(8'h34, v); chk("R10 div untouched", v, 1);
  endtask

  task automatic t_readback_r11();
    logic [31:0] v;
    wr(8'h00, 32'h1234_5678);
    rd(8'h00, v); chk("R11 match", v, 32'h1234_5678);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); chk("R11 ctrl", v, 3);
    wr(8'h08, 0);
    wr(8'h34, 32'hFFFF_FFFE);
    rd(8'h34, v); chk("R11 div", v, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_r1();
    t_count_r2();
    t_disabled_r3();
    t_clear_r4();
    t_div_r5();
    t_irq_r6();
    t_periodic_r7();
    t_wrap_r8();
    t_passed_r9();
    t_unmapped_r10();
    t_readback_r11();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule